// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port, and it turns slot events into interrupts. Software programs it through a 32-bit configuration write port that carries a word address, four byte enables and data. A combinational read port returns the same word. Slot control occupies bytes 0 and 1 of the word and slot status occupies bytes 2 and 3. Two one-cycle strobes from the port's environment report a hot-add and a removal request. A presence input gives the state of the slot while reset is held.

The block keeps one interrupt condition. When that condition changes and message interrupts are enabled, it emits a one-cycle message strobe that carries the vector number supplied on its vector input. When message interrupts are disabled, a level interrupt output tracks the condition. The block also raises a one-cycle detach request when software powers down an occupied slot. It raises a one-cycle busy strobe when a hot-plug request arrives while the slot interlock is engaged.

Top module: `hp_slot_ctrl`

## Requirements
- R1: While reset is held, slot control loads all enables to 0 and the attention indicator (bits 7:6) to 11 (off). The power indicator (bits 9:8) loads 01 (on) if `card_present` is high and 11 (off) otherwise. The power controller bit (10) loads 0. Slot status loads 0 except presence state (bit 6), which copies `card_present`. `intx` is low.
- R2: Slot status event bits are write-1-to-clear: attention button (bit 0), presence changed (bit 3) and command completed (bit 4). Writing 0 to an event bit leaves it set. Presence state (bit 6) and interlock state (bit 7) are not changed by status writes.
- R3: The interrupt condition is true only when the hot-plug interrupt enable (control bit 5) is set and at least one of status bits 0, 3 and 4 is set together with the enable at the same control bit position.
- R4: With `msi_en` low, `intx` equals the interrupt condition one cycle after the state changes. With `msi_en` high, `intx` holds its value.
- R5: With `msi_en` high, each change of the interrupt condition produces exactly one `msg_valid` pulse carrying `irq_vec`. Setting an event bit that is already set, or any update that leaves the condition unchanged, produces no pulse.
- R6: Every write that enables byte 0 or byte 1 of slot control is one command and sets command completed. In the same write, any status clear is applied first, so the command's own completion survives.
- R7: Writing 1 to control bit 11 toggles interlock state (status bit 7). Control bit 11 always reads 0.
- R8: A control write with byte 1 enabled that sets the power controller bit to 1 and the power indicator to 11, while presence state is 1, pulses `detach_req`, clears presence state and sets presence changed. With no card present, the same write does not pulse `detach_req`.
- R9: A `hot_add` strobe sets presence state, presence changed and attention button. A `remove_req` strobe sets attention button. A card present at reset raises no event.
- R10: While interlock state is 1, `hot_add` and `remove_req` leave the status unchanged and pulse `busy` one cycle later.
- R11: `rd_data` returns {slot status, slot control} when `rd_addr` equals `SLOT_ADDR` and returns 0 at any other address. A write to another address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_present | input | 1 | Slot occupancy, sampled while reset is held |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, {status, control} |
| hot_add | input | 1 | One-cycle hot-add strobe |
| remove_req | input | 1 | One-cycle removal request strobe |
| msi_en | input | 1 | Message interrupts enabled |
| irq_vec | input | VEC_W | Vector number carried by messages |
| intx | output | 1 | Level interrupt |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_vec | output | VEC_W | Vector of the current message |
| detach_req | output | 1 | One-cycle detach request |
| busy | output | 1 | One-cycle refusal strobe for a locked slot |

## Verification
The assertions assume that `msi_en` only changes between operations and that `hot_add` and `remove_req` are single-cycle strobes, each taken against the registered lock state of the previous cycle. They also assume reset is held for at least one clock, so that every past value they read is a loaded register value. The stimulus drives each write, strobe and mode change on the falling edge for exactly one cycle. It never overlaps a strobe with a lock-toggling write, and it holds reset for several cycles at both the start and the mid-run reset.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    localparam int HALF_W = 16;

    // event bit positions (shared by control enables and status events)
    localparam int EV_BTN  = 0;
    localparam int EV_PRSC = 3;
    localparam int EV_DONE = 4;
    localparam int EV_N    = 5;

    // control fields
    localparam int CTL_IRQ_EN = 5;
    localparam int CTL_ATTN   = 6;
    localparam int CTL_PIND   = 8;
    localparam int CTL_PWR    = 10;
    localparam int CTL_LOCK   = 11;

    // status fields
    localparam int STS_PRES = 6;
    localparam int STS_LOCK = 7;

    localparam logic [EV_N-1:0] EV_SUPPORTED = 5'b11001;
    localparam logic [1:0]      IND_ON       = 2'b01;
    localparam logic [1:0]      IND_OFF      = 2'b11;

    typedef struct packed {
        logic              hit;
        logic              ctl_touch;
        logic              sts_touch;
        logic [HALF_W-1:0] ctl_mask;
        logic [HALF_W-1:0] ctl_data;
        logic [HALF_W-1:0] sts_clr;
    } slot_wr_t;

    typedef struct packed {
        logic [HALF_W-1:0] ctl;
        logic [HALF_W-1:0] sts;
        logic              cond;
        logic              intx;
        logic              msg;
        logic              detach;
        logic              busy;
    } slot_state_t;

endpackage

// File: rtl/hp_slot_wdec.sv
module hp_slot_wdec
    import hp_slot_pkg::*;
#(
    parameter int              ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] SLOT_ADDR = 10'h006
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    output slot_wr_t          wr_dec
);

    localparam int NBYTES = 4;

    logic [31:0] byte_mask;

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign byte_mask[8*b +: 8] = {8{wr_be[b]}};
        end
    endgenerate

    always_comb begin
        wr_dec.hit       = wr_en && (wr_addr == SLOT_ADDR);
        wr_dec.ctl_touch = |wr_be[1:0];
        wr_dec.sts_touch = |wr_be[3:2];
        wr_dec.ctl_mask  = byte_mask[15:0];
        wr_dec.ctl_data  = wr_data[15:0];
        wr_dec.sts_clr   = wr_data[31:16] & byte_mask[31:16];
    end

endmodule

// File: rtl/hp_slot_cond.sv
module hp_slot_cond
    import hp_slot_pkg::*;
(
    input  logic            irq_en,
    input  logic [EV_N-1:0] ev_en,
    input  logic [EV_N-1:0] ev_sts,
    output logic            cond
);

    always_comb begin
        cond = irq_en && |(ev_en & ev_sts & EV_SUPPORTED);
    end

endmodule

// File: rtl/hp_slot_core.sv
module hp_slot_core
    import hp_slot_pkg::*;
#(
    parameter int VEC_W        = 5,
    parameter bit HAS_PWR_CTRL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_present,
    input  slot_wr_t          wr_dec,
    input  logic              hot_add,
    input  logic              remove_req,
    input  logic              msi_en,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic [HALF_W-1:0] ctl_q,
    output logic [HALF_W-1:0] sts_q,
    output logic              intx,
    output logic              msg_valid,
    output logic [VEC_W-1:0]  msg_vec,
    output logic              detach_req,
    output logic              busy
);

    localparam logic [HALF_W-1:0] EN_WMASK  = 16'(EV_SUPPORTED) | (16'd1 << CTL_IRQ_EN);
    localparam logic [HALF_W-1:0] IND_WMASK = 16'(2'b11) << CTL_ATTN;
    localparam logic [HALF_W-1:0] PWR_WMASK = HAS_PWR_CTRL ?
                                              ((16'(2'b11) << CTL_PIND) | (16'd1 << CTL_PWR)) : '0;
    localparam logic [HALF_W-1:0] CTL_WMASK = EN_WMASK | IND_WMASK | PWR_WMASK;

    slot_state_t       st_d, st_q, st_rst;
    logic [VEC_W-1:0]  vec_d, vec_q;
    logic [HALF_W-1:0] wmask;
    logic              cond_next;
    logic              locked;
    logic              pwr_off_cmd;

    // reset image depends on slot occupancy
    always_comb begin
        st_rst                      = '0;
        st_rst.ctl[CTL_ATTN +: 2]   = IND_OFF;
        st_rst.ctl[CTL_PIND +: 2]   = (HAS_PWR_CTRL && card_present) ? IND_ON : IND_OFF;
        st_rst.sts[STS_PRES]        = card_present;
    end

    always_comb begin
        st_d        = st_q;
        st_d.msg    = 1'b0;
        st_d.detach = 1'b0;
        st_d.busy   = 1'b0;
        locked      = st_q.sts[STS_LOCK];
        wmask       = wr_dec.ctl_mask & CTL_WMASK;
        pwr_off_cmd = wr_dec.ctl_mask[CTL_PWR] && wr_dec.ctl_data[CTL_PWR] &&
                      wr_dec.ctl_mask[CTL_PIND] &&
                      (wr_dec.ctl_data[CTL_PIND +: 2] == IND_OFF);

        // status clears come first
        if (wr_dec.hit && wr_dec.sts_touch) begin
            st_d.sts[EV_N-1:0] = st_d.sts[EV_N-1:0] & ~(wr_dec.sts_clr[EV_N-1:0] & EV_SUPPORTED);
        end

        // a control write is one command
        if (wr_dec.hit && wr_dec.ctl_touch) begin
            st_d.ctl = (st_q.ctl & ~wmask) | (wr_dec.ctl_data & wmask);
            if (wr_dec.ctl_mask[CTL_LOCK] && wr_dec.ctl_data[CTL_LOCK]) begin
                st_d.sts[STS_LOCK] = ~st_q.sts[STS_LOCK];
            end
            if (st_q.sts[STS_PRES] && pwr_off_cmd) begin
                st_d.detach         = 1'b1;
                st_d.sts[STS_PRES]  = 1'b0;
                st_d.sts[EV_PRSC]   = 1'b1;
            end
            st_d.sts[EV_DONE] = 1'b1;
        end

        // external slot events
        if (hot_add) begin
            if (locked) begin
                st_d.busy = 1'b1;
            end else begin
                st_d.sts[STS_PRES] = 1'b1;
                st_d.sts[EV_PRSC]  = 1'b1;
                st_d.sts[EV_BTN]   = 1'b1;
            end
        end
        if (remove_req) begin
            if (locked) begin
                st_d.busy = 1'b1;
            end else begin
                st_d.sts[EV_BTN] = 1'b1;
            end
        end

        // notification on condition change only
        st_d.cond = cond_next;
        st_d.msg  = msi_en && (cond_next != st_q.cond);
        st_d.intx = msi_en ? st_q.intx : cond_next;
        vec_d     = st_d.msg ? irq_vec : vec_q;
    end

    hp_slot_cond i_cond (
        .irq_en (st_d.ctl[CTL_IRQ_EN]),
        .ev_en  (st_d.ctl[EV_N-1:0]),
        .ev_sts (st_d.sts[EV_N-1:0]),
        .cond   (cond_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= st_rst;
            vec_q <= '0;
        end else begin
            st_q  <= st_d;
            vec_q <= vec_d;
        end
    end

    assign ctl_q      = st_q.ctl;
    assign sts_q      = st_q.sts;
    assign intx       = st_q.intx;
    assign msg_valid  = st_q.msg;
    assign msg_vec    = vec_q;
    assign detach_req = st_q.detach;
    assign busy       = st_q.busy;

endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int                ADDR_W       = 10,
    parameter logic [ADDR_W-1:0] SLOT_ADDR    = 10'h006,
    parameter int                VEC_W        = 5,
    parameter bit                HAS_PWR_CTRL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_present,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              hot_add,
    input  logic              remove_req,
    input  logic              msi_en,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic              intx,
    output logic              msg_valid,
    output logic [VEC_W-1:0]  msg_vec,
    output logic              detach_req,
    output logic              busy
);

    slot_wr_t          wr_dec;
    logic              wr_hit;
    logic [HALF_W-1:0] ctl_q;
    logic [HALF_W-1:0] sts_q;

    hp_slot_wdec #(
        .ADDR_W    (ADDR_W),
        .SLOT_ADDR (SLOT_ADDR)
    ) i_wdec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .wr_dec  (wr_dec)
    );

    hp_slot_core #(
        .VEC_W        (VEC_W),
        .HAS_PWR_CTRL (HAS_PWR_CTRL)
    ) i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .card_present (card_present),
        .wr_dec       (wr_dec),
        .hot_add      (hot_add),
        .remove_req   (remove_req),
        .msi_en       (msi_en),
        .irq_vec      (irq_vec),
        .ctl_q        (ctl_q),
        .sts_q        (sts_q),
        .intx         (intx),
        .msg_valid    (msg_valid),
        .msg_vec      (msg_vec),
        .detach_req   (detach_req),
        .busy         (busy)
    );

    assign wr_hit  = wr_dec.hit;
    assign rd_data = (rd_addr == SLOT_ADDR) ? {sts_q, ctl_q} : 32'h0;

endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        msi_en,
    input logic        ctl_wr,
    input logic        lock_wr,
    input logic        ext_req,
    input logic [15:0] sts_q,
    input logic        intx,
    input logic        msg_valid,
    input logic        detach_req,
    input logic        busy
);

    // R5
    msg_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(msi_en));

    // R4
    intx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(msi_en) |-> $stable(intx));

    // R6
    cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr) |-> sts_q[4]);

    // R7
    lock_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_wr) |-> (sts_q[7] != $past(sts_q[7])));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($past(sts_q[7]) && $past(ext_req)));

    // R8
    detach_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detach_req |-> (!sts_q[6] && sts_q[3] && $past(sts_q[6])));

endmodule

bind hp_slot_ctrl hp_slot_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msi_en     (msi_en),
    .ctl_wr     (wr_hit && (|wr_be[1:0])),
    .lock_wr    (wr_hit && wr_be[1] && wr_data[11]),
    .ext_req    (hot_add || remove_req),
    .sts_q      (sts_q),
    .intx       (intx),
    .msg_valid  (msg_valid),
    .detach_req (detach_req),
    .busy       (busy)
);

// File: tb/test_hp_slot_ctrl.sv
module test_hp_slot_ctrl;

    localparam int                ADDR_W = 10;
    localparam logic [ADDR_W-1:0] SLOT   = 10'h006;
    localparam int                VEC_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              card_present = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = SLOT;
    logic [3:0]        wr_be = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = SLOT;
    logic [31:0]       rd_data;
    logic              hot_add = 1'b0;
    logic              remove_req = 1'b0;
    logic              msi_en = 1'b0;
    logic [VEC_W-1:0]  irq_vec = 5'd9;
    logic              intx, msg_valid, detach_req, busy;
    logic [VEC_W-1:0]  msg_vec;

    int checks = 0;
    int errors = 0;
    logic [VEC_W-1:0] exp_q[$];

    always #5 clk = ~clk;

    hp_slot_ctrl #(.ADDR_W(ADDR_W), .SLOT_ADDR(SLOT), .VEC_W(VEC_W)) i_hp_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .card_present(card_present),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .hot_add(hot_add), .remove_req(remove_req),
        .msi_en(msi_en), .irq_vec(irq_vec),
        .intx(intx), .msg_valid(msg_valid), .msg_vec(msg_vec),
        .detach_req(detach_req), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] be, input logic [31:0] d,
                             input logic [ADDR_W-1:0] a = SLOT);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0; wr_addr = SLOT;
    endtask

    task automatic strobe_add();
        @(negedge clk); hot_add = 1'b1;
        @(negedge clk); hot_add = 1'b0;
    endtask

    task automatic strobe_rm();
        @(negedge clk); remove_req = 1'b1;
        @(negedge clk); remove_req = 1'b0;
    endtask

    task automatic expect_msg(input logic [VEC_W-1:0] v);
        exp_q.push_back(v);
    endtask

    task automatic do_reset(input logic present);
        @(negedge clk);
        rst_n = 1'b0; card_present = present;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // scoreboard monitor for message pulses (R5)
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5: actual=unexpected message vec=%0d expected=none", msg_vec);
            end else begin
                logic [VEC_W-1:0] e;
                e = exp_q.pop_front();
                if (msg_vec !== e) begin
                    errors++;
                    $display("FAIL R5: actual vec=%0d expected vec=%0d", msg_vec, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        @(negedge clk);
        // R1 reset image with card present, R9 no boot event
        chk("R1 reset word", rd_data, 32'h0040_01C0);
        chk("R1 intx low", {31'b0, intx}, 32'h0);
        // R11 other address reads 0
        rd_addr = SLOT + 1'b1;
        #1 chk("R11 other address", rd_data, 32'h0);
        rd_addr = SLOT;
        // R11 write elsewhere ignored
        cfg_write(4'b0011, 32'h0000_0021, SLOT + 1'b1);
        chk("R11 foreign write", rd_data, 32'h0040_01C0);

        // R6 command completes, R3 no condition without completion enable
        cfg_write(4'b0001, 32'h0000_00E1);
        chk("R6 command done", rd_data, 32'h0050_01E1);
        chk("R3 cond off", {31'b0, intx}, 32'h0);

        // R9 removal sets button event, R4 intx follows
        strobe_rm();
        chk("R9 button event", rd_data, 32'h0051_01E1);
        chk("R4 intx rises", {31'b0, intx}, 32'h1);

        // R2 writing zeros clears nothing
        cfg_write(4'b0100, 32'h0000_0000);
        chk("R2 zero write", rd_data, 32'h0051_01E1);
        // R2 clear button, presence and lock bits untouched
        cfg_write(4'b0100, 32'h00C1_0000);
        chk("R2 w1c", rd_data, 32'h0050_01E1);
        chk("R4 intx falls", {31'b0, intx}, 32'h0);

        // message mode
        msi_en = 1'b1;
        expect_msg(5'd9);
        cfg_write(4'b0001, 32'h0000_00F9);
        chk("R4 intx held in message mode", {31'b0, intx}, 32'h0);
        // R5 already-set / unchanged condition: no message
        strobe_rm();
        strobe_rm();
        chk("R5 repeated event", rd_data, 32'h0051_01F9);

        irq_vec = 5'd22;
        expect_msg(5'd22);
        cfg_write(4'b0100, 32'h0011_0000);
        chk("R5 fall clears", rd_data, 32'h0040_01F9);

        // R7 interlock toggle, bit 11 reads 0
        expect_msg(5'd22);
        cfg_write(4'b0010, 32'h0000_0900);
        chk("R7 lock engaged", rd_data, 32'h00D0_01F9);

        // R10 refusals while locked
        strobe_add();
        chk("R10 busy on add", {31'b0, busy}, 32'h1);
        chk("R10 add refused", rd_data, 32'h00D0_01F9);
        strobe_rm();
        chk("R10 busy on remove", {31'b0, busy}, 32'h1);
        chk("R10 remove refused", rd_data, 32'h00D0_01F9);

        // R6 ordering: clear done and issue command together; R7 unlock
        cfg_write(4'b0110, 32'h0010_0900);
        chk("R6 clear then complete", rd_data, 32'h0050_01F9);
        chk("R10 busy idle", {31'b0, busy}, 32'h0);

        // R8 detach with card present
        cfg_write(4'b0010, 32'h0000_0700);
        chk("R8 detach pulse", {31'b0, detach_req}, 32'h1);
        chk("R8 detach state", rd_data, 32'h0018_07F9);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'b0, detach_req}, 32'h0);
        cfg_write(4'b0010, 32'h0000_0700);
        chk("R8 no card no detach", {31'b0, detach_req}, 32'h0);

        // R9 hot-add
        strobe_add();
        chk("R9 hot add", rd_data, 32'h0059_07F9);
        chk("R9 add not busy", {31'b0, busy}, 32'h0);

        expect_msg(5'd22);
        cfg_write(4'b0100, 32'h001F_0000);
        chk("R2 clear all", rd_data, 32'h0040_07F9);

        // level mode again, R3 master enable gates
        msi_en = 1'b0;
        strobe_rm();
        chk("R4 intx level", {31'b0, intx}, 32'h1);
        cfg_write(4'b0001, 32'h0000_00D9);
        chk("R3 master enable off", {31'b0, intx}, 32'h0);

        // R1 reset with empty slot
        do_reset(1'b0);
        @(negedge clk);
        chk("R1 empty reset", rd_data, 32'h0000_03C0);
        chk("R1 intx after reset", {31'b0, intx}, 32'h0);

        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5: actual=%0d messages missing expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule